// File: doc/BRIEF.md
# Interrupt Request Aggregator with Hold-off

This block collects a set of internal event sources into a single interrupt request line for the whole device. The sources are a few general-purpose I/O pins and a group of single-bit internal event inputs. These inputs are the general-purpose timer, the FIFO level events and the wake events. Each source owns a sticky status bit. Software clears a status bit by writing one to it. A per-source enable mask and a master enable decide which pending sources may drive the line.

The line is shaped for the board. Its active level is programmable. It can be driven push-pull, or in open-drain style, where it is driven only while active so that other devices can share it. After the line goes inactive, a programmable hold-off keeps it released for a minimum time before it may assert again. The hold-off is counted in ticks of a prescaler, with `TICK_DIV` core clocks per tick (for example 10 µs). GPIO pins are synchronised to the core clock. On each pin, only a transition in the programmed direction sets status.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every register reads zero. The line is then inactive: push-pull, active-low, so `irq_o`=1 and `irq_oe_o`=1.
- R2: When `evt_i[k]` is high in a cycle, status bit `NUM_GPIO+k` is set. A set status bit stays set until software clears it.
- R3: Writing address 0 clears each status bit whose write-data bit is 1, and leaves the bits written 0 unchanged. If a bit is set and cleared in the same cycle, the set wins.
- R4: The line becomes active one cycle after master enable (config bit 0) is 1 and (status AND enable) is non-zero, unless a hold-off is running. It goes inactive one cycle after that condition drops.
- R5: Config bit 1 selects the active level: 1 means active-high, 0 means active-low. In push-pull mode, `irq_o` carries the active level while the line is active and the opposite level otherwise.
- R6: Config bit 2 selects open-drain. In that mode `irq_oe_o` is 1 only while the line is active. In push-pull mode `irq_oe_o` is always 1.
- R7: With hold-off value H in config bits [15:8], a line that goes inactive while a source is pending stays inactive for H*TICK_DIV+1 cycles. With H=0 it stays inactive for one cycle.
- R8: Each GPIO pin passes a two-flop synchroniser. Polarity register bit i set to 1 selects a rising edge on pin i, and 0 selects a falling edge. Status bit i is set only on a transition in the selected direction. A steady level, or a transition in the other direction, never sets it.
- R9: Reads are combinational from `reg_addr_i`: 0 status, 1 enable, 2 config, 3 GPIO polarity. Enable bits at and above `NUM_GPIO+NUM_EVT` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | NUM_GPIO | Asynchronous GPIO pin levels |
| evt_i | input | NUM_EVT | Internal event inputs, active high |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | DW | Write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | DW | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt line level |
| irq_oe_o | output | 1 | Output enable for the line pad |

## Verification
The line logic is swept over every combination of event status pattern and enable mask on the event bits. This separates AND-then-OR masking from bits that leak through unmasked. Each of the four level and drive-mode settings is tried with the line both idle and active. This catches a swapped polarity or output enable. Each GPIO pin is driven in both directions under both polarity settings, and is also held steady after a clear. This tells edge detection apart from level detection and from the opposite edge. Several hold-off values are timed to the cycle, and a set that coincides with a clear is tried to expose the wrong priority.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_EN   = 2'd1,
    REG_CFG  = 2'd2,
    REG_GPOL = 2'd3
  } reg_sel_e;

  localparam int CFG_MASTER   = 0;
  localparam int CFG_ACT_HI   = 1;
  localparam int CFG_OPEN_DRN = 2;
  localparam int CFG_HOLD_LSB = 8;
endpackage

// File: rtl/irq_gpio_edge.sv
module irq_gpio_edge #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] rise_sel_i,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pin_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign edge_o[g] = rise_sel_i[g] ? (s2_q & ~s3_q) : (~s2_q & s3_q);
  end
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int HOLD_W   = 8,
  parameter int TICK_DIV = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pending_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              active_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_MAX = PW'(TICK_DIV - 1);

  logic              active_q;
  logic [HOLD_W-1:0] cnt_q;
  logic [PW-1:0]     pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      pre_q    <= '0;
    end else if (active_q) begin
      if (!pending_i) begin
        active_q <= 1'b0;
        cnt_q    <= hold_i;
        pre_q    <= '0;
      end
    end else if (cnt_q != '0) begin
      if (pre_q == PRE_MAX) begin
        pre_q <= '0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end else begin
      active_q <= pending_i;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive (
  input  logic active_i,
  input  logic act_hi_i,
  input  logic open_drain_i,
  output logic line_o,
  output logic oe_o
);
  assign line_o = active_i ? act_hi_i : ~act_hi_i;
  assign oe_o   = open_drain_i ? active_i : 1'b1;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_GPIO = 3,
  parameter int NUM_EVT  = 4,
  parameter int HOLD_W   = 8,
  parameter int TICK_DIV = 1000,
  parameter int DW       = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_GPIO-1:0] gpio_i,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [DW-1:0]       reg_wdata_i,
  input  logic                reg_we_i,
  output logic [DW-1:0]       reg_rdata_o,
  output logic                irq_o,
  output logic                irq_oe_o
);
  localparam int NSRC = NUM_GPIO + NUM_EVT;

  logic [NSRC-1:0]     status_q, enable_q, src_set;
  logic [NUM_GPIO-1:0] gpol_q, gpio_edge;
  logic                cfg_master, cfg_act_hi, cfg_od;
  logic [HOLD_W-1:0]   cfg_hold;
  logic                pending, line_active, stat_clr_wr;

  irq_gpio_edge #(.N(NUM_GPIO)) u_edge (
    .clk_i, .rst_ni, .pin_i(gpio_i), .rise_sel_i(gpol_q), .edge_o(gpio_edge)
  );

  assign src_set     = {evt_i, gpio_edge};
  assign stat_clr_wr = reg_we_i && (reg_addr_i == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q   <= '0;
      enable_q   <= '0;
      gpol_q     <= '0;
      cfg_master <= 1'b0;
      cfg_act_hi <= 1'b0;
      cfg_od     <= 1'b0;
      cfg_hold   <= '0;
    end else begin
      // set has priority over a coincident clear
      status_q <= (status_q & ~(stat_clr_wr ? reg_wdata_i[NSRC-1:0] : '0)) | src_set;
      if (reg_we_i) begin
        unique case (reg_addr_i)
          REG_EN:   enable_q <= reg_wdata_i[NSRC-1:0];
          REG_CFG: begin
            cfg_master <= reg_wdata_i[CFG_MASTER];
            cfg_act_hi <= reg_wdata_i[CFG_ACT_HI];
            cfg_od     <= reg_wdata_i[CFG_OPEN_DRN];
            cfg_hold   <= reg_wdata_i[CFG_HOLD_LSB +: HOLD_W];
          end
          REG_GPOL: gpol_q <= reg_wdata_i[NUM_GPIO-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_STAT: reg_rdata_o = DW'(status_q);
      REG_EN:   reg_rdata_o = DW'(enable_q);
      REG_CFG: begin
        reg_rdata_o[CFG_MASTER]               = cfg_master;
        reg_rdata_o[CFG_ACT_HI]               = cfg_act_hi;
        reg_rdata_o[CFG_OPEN_DRN]             = cfg_od;
        reg_rdata_o[CFG_HOLD_LSB +: HOLD_W]   = cfg_hold;
      end
      default:  reg_rdata_o = DW'(gpol_q);
    endcase
  end

  assign pending = cfg_master && ((status_q & enable_q) != '0);

  irq_holdoff #(.HOLD_W(HOLD_W), .TICK_DIV(TICK_DIV)) u_hold (
    .clk_i, .rst_ni, .pending_i(pending), .hold_i(cfg_hold), .active_o(line_active)
  );

  irq_line_drive u_drive (
    .active_i(line_active), .act_hi_i(cfg_act_hi), .open_drain_i(cfg_od),
    .line_o(irq_o), .oe_o(irq_oe_o)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NSRC   = 7,
  parameter int HOLD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              irq_oe_o,
  input logic              active_i,
  input logic              pending_i,
  input logic [NSRC-1:0]   status_i,
  input logic              clr_wr_i,
  input logic [HOLD_W-1:0] hold_i,
  input logic              act_hi_i,
  input logic              od_i
);
  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr_i |=> ((status_i & $past(status_i)) == $past(status_i)));

  p_rise_needs_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_i) |-> $past(pending_i));

  p_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o |-> (irq_o == (active_i ? act_hi_i : !act_hi_i)));

  p_od_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_i && !active_i) |-> !irq_oe_o);

  p_pp_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !od_i |-> irq_oe_o);

  p_holdoff_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hold_i != '0) && $fell(active_i)) |=> !active_i);
endmodule

bind irq_aggregator irq_agg_chk #(.NSRC(NSRC), .HOLD_W(HOLD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .irq_oe_o(irq_oe_o),
  .active_i(line_active), .pending_i(pending), .status_i(status_q),
  .clr_wr_i(stat_clr_wr), .hold_i(cfg_hold), .act_hi_i(cfg_act_hi), .od_i(cfg_od)
);

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  localparam int NG = 3, NE = 4, NS = NG + NE, TD = 4;

  logic clk = 0, rst_n = 0;
  logic [NG-1:0] gpio = '0;
  logic [NE-1:0] evt = '0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic we = 0, irq, oe;
  int errors = 0, checks = 0;
  logic cur_pol = 0, cur_od = 0;

  always #10 clk = ~clk;

  irq_aggregator #(.NUM_GPIO(NG), .NUM_EVT(NE), .HOLD_W(8), .TICK_DIV(TD), .DW(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .evt_i(evt), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_we_i(we), .reg_rdata_o(rdata), .irq_o(irq), .irq_oe_o(oe)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cfg(logic m, logic p, logic od, logic [7:0] h);
    cur_pol = p; cur_od = od;
    wr(2'd2, {h, 5'd0, od, p, m});
  endtask

  function automatic logic line_on();
    return oe === 1'b1 && irq === cur_pol;
  endfunction

  task automatic chk_line(string req, logic exp_on);
    logic [1:0] e;
    e[1] = exp_on ? 1'b1 : !cur_od;
    e[0] = exp_on ? cur_pol : !cur_pol;
    chk(req, {14'd0, oe, irq}, {14'd0, e});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reg", v, 16'h0); end
    chk("R1 line", {14'd0, oe, irq}, 16'h3);

    // R9 enable readback width
    wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R9 enable width", v, 16'h007F);
    cfg(1, 0, 0, 8'd5); rd(2'd2, v); chk("R9 config", v, 16'h0501);

    // R5/R6 all level and drive combos
    wr(2'd1, 16'h0078);
    for (int p = 0; p < 2; p++) for (int od = 0; od < 2; od++) begin
      cfg(1, p[0], od[0], 8'd0);
      wr(2'd0, 16'hFFFF); idle(3);
      chk_line("R5 R6 idle", 0);
      @(negedge clk); evt[0] = 1; @(negedge clk); evt[0] = 0; idle(2);
      chk_line("R5 R6 active", 1);
      wr(2'd0, 16'hFFFF); idle(2);
      chk_line("R4 R6 released", 0);
    end

    // R4/R2 exhaustive status x enable over event bits
    cfg(1, 1, 0, 8'd0);
    for (int sp = 0; sp < 16; sp++) for (int en = 0; en < 16; en++) begin
      wr(2'd0, 16'hFFFF);
      wr(2'd1, 16'(en) << NG);
      @(negedge clk); evt = 4'(sp); @(negedge clk); evt = '0; idle(3);
      chk_line("R4 mask", (sp & en) != 0);
      rd(2'd0, v); chk("R2 status", v, 16'(sp) << NG);
    end

    // R4 master enable
    wr(2'd1, 16'h0078); cfg(0, 1, 0, 8'd0);
    @(negedge clk); evt = '1; @(negedge clk); evt = '0; idle(3);
    chk_line("R4 master off", 0);
    cfg(1, 1, 0, 8'd0); idle(2);
    chk_line("R4 master on", 1);

    // R3 partial clear and set-over-clear
    wr(2'd0, 16'hFFFF);
    @(negedge clk); evt = 4'b0011; @(negedge clk); evt = '0;
    wr(2'd0, 16'h0008); rd(2'd0, v); chk("R3 partial clear", v, 16'h0010);
    @(negedge clk); addr = 2'd0; wdata = 16'h0010; we = 1; evt[1] = 1;
    @(negedge clk); we = 0; evt = '0;
    rd(2'd0, v); chk("R3 set wins", v, 16'h0010);
    wr(2'd0, 16'h0000); rd(2'd0, v); chk("R3 zero write", v, 16'h0010);

    // R7 hold-off timing
    wr(2'd1, 16'h0008);
    for (int h = 0; h < 4; h++) begin
      cfg(1, 1, 0, 8'(h));
      wr(2'd0, 16'hFFFF); idle(2 + h * TD);
      @(negedge clk); evt[0] = 1; @(negedge clk); evt[0] = 0; idle(2);
      chk_line("R7 pre", 1);
      wr(2'd0, 16'h0008);
      evt[0] = 1; @(negedge clk); evt[0] = 0;
      n = 0;
      while (!line_on() && n < 1000) begin n++; @(negedge clk); end
      chk("R7 hold cycles", 16'(n), 16'(h * TD + 1));
    end

    // R8 GPIO edges per pin and polarity
    wr(2'd1, 16'h0000);
    for (int p = 0; p < NG; p++) for (int r = 0; r < 2; r++) begin
      wr(2'd3, r ? (16'd1 << p) : 16'd0);
      gpio[p] = !r[0]; idle(5);
      wr(2'd0, 16'hFFFF);
      gpio[p] = r[0]; idle(5);
      rd(2'd0, v); chk("R8 edge sets", v, 16'd1 << p);
      wr(2'd0, 16'hFFFF); idle(5);
      rd(2'd0, v); chk("R8 level ignored", v, 16'h0);
      gpio[p] = !r[0]; idle(5);
      rd(2'd0, v); chk("R8 wrong edge", v, 16'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule